// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock sent to an SD card from the host's base clock. Software programs a 10-bit divisor N through two write ports: a 2-bit upper field and an 8-bit lower field. When N is zero the base clock is passed straight through. For any N from 1 to 1023 the base clock is divided by 2N, with the output high for exactly N base cycles and low for exactly N base cycles.

A single enable input starts and stops the card clock. The divisor fields can be changed only while the enable is low, and the running divider takes up a new divisor only while it is stopped. When the enable drops during a high phase, that high phase runs to its full length before the output stops low. No shortened pulse ever reaches the card. A stable flag tells the host that one complete output period has gone by since the clock was enabled.

Top module: `sdcard_clkgen`

## Requirements
- R1: After a synchronous active-low reset, card_clk and clk_stable are low and both divisor fields hold zero, so enabling straight after reset gives bypass operation.
- R2: The divisor N is formed as {upper field, lower field}. hi_wr loads hi_val into bits 9:8 and lo_wr loads lo_val into bits 7:0. Each write leaves the other field unchanged.
- R3: With N = 0 and clk_en high, card_clk follows base_clk: high while base_clk is high and low while it is low. The gate opens and closes only at falling edges of base_clk.
- R4: With N from 1 to 1023, card_clk goes high at the first base-clock rising edge that samples clk_en high. It then stays high for N cycles and low for N cycles, repeating.
- R5: A hi_wr or lo_wr that arrives while clk_en is high changes neither field.
- R6: The divider takes the field value only while it is stopped and clk_en is low. A divisor written with clk_en low takes effect at the next enable, provided clk_en stays low for at least one more base-clock edge after the write.
- R7: If clk_en is sampled low during a high phase of a divided clock, the high phase completes its full N cycles and then card_clk stays low.
- R8: If clk_en is sampled low during a low phase of a divided clock, card_clk stays low from that edge onward.
- R9: clk_stable rises at the edge that starts the second high phase, which is 2N cycles after the first rising edge of card_clk. In bypass it rises at the second rising edge of base_clk after the gate opens.
- R10: clk_stable is low after any base-clock rising edge that samples clk_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_clk | input | 1 | Base clock from which the card clock is derived |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Card clock enable |
| hi_wr | input | 1 | Write strobe for the upper divisor field |
| hi_val | input | 2 | Value for divisor bits 9:8 |
| lo_wr | input | 1 | Write strobe for the lower divisor field |
| lo_val | input | 8 | Value for divisor bits 7:0 |
| card_clk | output | 1 | Clock sent to the card |
| clk_stable | output | 1 | High once a full output period has completed since enable |

## Verification
A corrupted divisor register or counter shows up as a high or low phase of the wrong length. The bench catches it within one output period of enable, because it compares card_clk against the computed phase on every base-clock cycle over two full periods, for N = 1..12 and for the field-boundary values. A stuck stop state shows up in the base-clock cycles right after a disable: the output keeps toggling, or a high phase ends early. A stale active divisor shows up at the next enable as the old period.

// File: rtl/sdclk_pkg.sv
// Shared types for the SD card clock generator.
// Assumes: the divider control is a three-state machine, encoded in two bits.
package sdclk_pkg;

    // States of the divided-clock control machine.
    typedef enum logic [1:0] {
        DIV_IDLE  = 2'd0,   // stopped, output low, may take a new divisor
        DIV_RUN   = 2'd1,   // toggling every N base cycles
        DIV_DRAIN = 2'd2    // enable gone, finishing the current high phase
    } div_state_e;

endpackage

// File: rtl/sdclk_div_regs.sv
// Divisor field registers plus the active divisor copy used by the divider.
// Does: captures the upper and lower field writes only while the enable is low,
//       and copies the assembled divisor into the active register only while
//       both clock paths are stopped and the enable is low.
// Assumes: the write strobes are synchronous to clk and last one cycle.
module sdclk_div_regs #(
    parameter int HI_W = 2,
    parameter int LO_W = 8,
    localparam int DIV_W = HI_W + LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             hi_wr,
    input  logic [HI_W-1:0]  hi_val,
    input  logic             lo_wr,
    input  logic [LO_W-1:0]  lo_val,
    input  logic             paths_idle,
    output logic [DIV_W-1:0] active_div
);

    logic [HI_W-1:0] hi_field;
    logic [LO_W-1:0] lo_field;

    // Capture the field writes; anything written while enabled is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_field <= '0;
            lo_field <= '0;
        end else if (!clk_en) begin
            if (hi_wr) hi_field <= hi_val;
            if (lo_wr) lo_field <= lo_val;
        end
    end

    // Copy the assembled divisor while nothing is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_div <= '0;
        end else if (!clk_en && paths_idle) begin
            active_div <= {hi_field, lo_field};
        end
    end

    // R5: the fields hold while the enable is high.
    a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> ($stable(hi_field) && $stable(lo_field)));

    // R6: the active divisor never moves while a clock path is busy.
    a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !paths_idle |=> $stable(active_div));

endmodule

// File: rtl/sdclk_divider.sv
// Divide-by-2N card clock path for N >= 1.
// Does: toggles its output after every N base cycles. On disable it stops low
//       immediately from a low phase, or after finishing a high phase.
//       Flags the low-to-high toggle that closes each full period.
// Assumes: div is held constant whenever busy is high.
module sdclk_divider
    import sdclk_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [DIV_W-1:0] div,
    input  logic             gate_open,
    output logic             div_q,
    output logic             busy,
    output logic             period_done
);

    div_state_e       state;
    logic [DIV_W-1:0] cnt;
    logic             last;

    // Marks the final base cycle of the current half period.
    assign last = (cnt == div - DIV_W'(1));

    // Run, drain and stop the divided clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DIV_IDLE;
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            case (state)
                DIV_IDLE: begin
                    if (clk_en && (div != '0) && !gate_open) begin
                        state <= DIV_RUN;
                        cnt   <= '0;
                        div_q <= 1'b1;
                    end
                end
                DIV_RUN: begin
                    if (!clk_en && !div_q) begin
                        state <= DIV_IDLE;
                        cnt   <= '0;
                    end else if (!clk_en && last) begin
                        state <= DIV_IDLE;
                        cnt   <= '0;
                        div_q <= 1'b0;
                    end else if (!clk_en) begin
                        state <= DIV_DRAIN;
                        cnt   <= cnt + DIV_W'(1);
                    end else if (last) begin
                        cnt   <= '0;
                        div_q <= ~div_q;
                    end else begin
                        cnt   <= cnt + DIV_W'(1);
                    end
                end
                DIV_DRAIN: begin
                    if (clk_en) begin
                        state <= DIV_RUN;
                        if (last) begin
                            cnt   <= '0;
                            div_q <= ~div_q;
                        end else begin
                            cnt <= cnt + DIV_W'(1);
                        end
                    end else if (last) begin
                        state <= DIV_IDLE;
                        cnt   <= '0;
                        div_q <= 1'b0;
                    end else begin
                        cnt <= cnt + DIV_W'(1);
                    end
                end
                default: begin
                    state <= DIV_IDLE;
                    cnt   <= '0;
                    div_q <= 1'b0;
                end
            endcase
        end
    end

    // Busy whenever the path is not stopped.
    assign busy = (state != DIV_IDLE);

    // The toggle back to high that closes a full period.
    assign period_done = (state == DIV_RUN) && clk_en && last && !div_q;

    // R4: the half-period counter stays below N.
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state != DIV_IDLE) |-> (cnt < div));

    // R7: draining only happens during a high phase.
    a_r7_drain_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DIV_DRAIN) |-> div_q);

    // R8: a stopped divider holds its output low.
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DIV_IDLE) |-> !div_q);

endmodule

// File: rtl/sdclk_bypass_gate.sv
// Full-rate path for N = 0: the base clock ANDed with an enable that is
// registered on the falling edge, so the gate only opens or closes while the
// base clock is low.
// Assumes: bypass_sel and clk_en are synchronous to the rising edge.
module sdclk_bypass_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic bypass_sel,
    input  logic div_busy,
    output logic gate_open,
    output logic byp_clk
);

    // Register the gate on the falling edge to avoid truncated pulses.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            gate_open <= 1'b0;
        end else begin
            gate_open <= clk_en && bypass_sel && !div_busy;
        end
    end

    // Gated base clock.
    assign byp_clk = clk & gate_open;

    // R3: the bypass gate and the divider are never active together.
    a_r3_gate_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> !div_busy);

endmodule

// File: rtl/sdclk_stable.sv
// Clock-stable flag: set once a full output period is complete, cleared
// at any edge that samples the enable low.
// Assumes: period_done pulses for one cycle at each closing toggle.
module sdclk_stable (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic period_done,
    input  logic gate_open,
    output logic stable
);

    logic byp_seen;

    // Remember that the bypass gate was open at the previous rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) byp_seen <= 1'b0;
        else        byp_seen <= gate_open;
    end

    // Set on a completed period, hold while enabled, clear on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) stable <= 1'b0;
        else        stable <= clk_en && (stable || period_done || (byp_seen && gate_open));
    end

    // R10: a disable sampled at an edge leaves the flag low.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !stable);

endmodule

// File: rtl/sdcard_clkgen.sv
// SD card clock generator top level.
// Does: joins the divisor registers, the divide-by-2N path, the bypass gate
//       and the stable flag. The card clock is the OR of the two paths, which
//       are never active together.
// Assumes: writes and enable are synchronous to base_clk.
module sdcard_clkgen #(
    parameter int HI_W = 2,
    parameter int LO_W = 8,
    localparam int DIV_W = HI_W + LO_W
) (
    input  logic            base_clk,
    input  logic            rst_n,
    input  logic            clk_en,
    input  logic            hi_wr,
    input  logic [HI_W-1:0] hi_val,
    input  logic            lo_wr,
    input  logic [LO_W-1:0] lo_val,
    output logic            card_clk,
    output logic            clk_stable
);

    logic [DIV_W-1:0] active_div;
    logic             div_q;
    logic             div_busy;
    logic             period_done;
    logic             gate_open;
    logic             byp_clk;
    logic             paths_idle;
    logic             bypass_sel;

    // Both paths stopped: a new divisor may be taken.
    assign paths_idle = !div_busy && !gate_open;
    // A zero divisor selects the full-rate path.
    assign bypass_sel = (active_div == '0);

    sdclk_div_regs #(.HI_W(HI_W), .LO_W(LO_W)) u_regs (
        .clk        (base_clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .hi_wr      (hi_wr),
        .hi_val     (hi_val),
        .lo_wr      (lo_wr),
        .lo_val     (lo_val),
        .paths_idle (paths_idle),
        .active_div (active_div)
    );

    sdclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk         (base_clk),
        .rst_n       (rst_n),
        .clk_en      (clk_en),
        .div         (active_div),
        .gate_open   (gate_open),
        .div_q       (div_q),
        .busy        (div_busy),
        .period_done (period_done)
    );

    sdclk_bypass_gate u_byp (
        .clk        (base_clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .bypass_sel (bypass_sel),
        .div_busy   (div_busy),
        .gate_open  (gate_open),
        .byp_clk    (byp_clk)
    );

    sdclk_stable u_stable (
        .clk         (base_clk),
        .rst_n       (rst_n),
        .clk_en      (clk_en),
        .period_done (period_done),
        .gate_open   (gate_open),
        .stable      (clk_stable)
    );

    // Card clock from whichever path is active.
    assign card_clk = div_q | byp_clk;

    // R1: reset leaves the stable flag low after the reset edge.
    a_r1_reset_quiet: assert property (@(posedge base_clk)
        !rst_n |=> !clk_stable);

endmodule

// File: tb/tb_sdcard_clkgen.sv
// Self-checking bench: sweeps divisors 1..12 and the field boundaries,
// covers bypass, disable in both phases and ignored writes.
module tb_sdcard_clkgen;

    logic       base_clk = 1'b0;
    logic       rst_n    = 1'b0;
    logic       clk_en   = 1'b0;
    logic       hi_wr    = 1'b0;
    logic [1:0] hi_val   = '0;
    logic       lo_wr    = 1'b0;
    logic [7:0] lo_val   = '0;
    logic       card_clk;
    logic       clk_stable;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 base_clk = ~base_clk;   // 125 MHz

    sdcard_clkgen dut (
        .base_clk   (base_clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .hi_wr      (hi_wr),
        .hi_val     (hi_val),
        .lo_wr      (lo_wr),
        .lo_val     (lo_val),
        .card_clk   (card_clk),
        .clk_stable (clk_stable)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // Advance to 2 ns after the next rising edge.
    task automatic tick();
        @(posedge base_clk);
        #2;
    endtask

    task automatic write_fields(input bit do_hi, input bit do_lo, input int n);
        hi_wr  = do_hi;
        hi_val = 2'(n >> 8);
        lo_wr  = do_lo;
        lo_val = 8'(n);
        tick();
        hi_wr = 1'b0;
        lo_wr = 1'b0;
        tick();
        tick();
    endtask

    // Enable, check two full periods cycle by cycle, then disable in a low phase.
    task automatic run_div(input int n, input string req);
        clk_en = 1'b1;
        for (int k = 0; k < 4 * n; k++) begin
            tick();
            check(req, int'(card_clk), ((k / n) % 2 == 0) ? 1 : 0);
            if (k == 2 * n - 1) check("R9", int'(clk_stable), 0);
            if (k == 2 * n)     check("R9", int'(clk_stable), 1);
        end
        clk_en = 1'b0;   // last sample was in a low phase
        tick();
        check("R8", int'(card_clk), 0);
        check("R10", int'(clk_stable), 0);
        tick();
        check("R8", int'(card_clk), 0);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        check("R1", int'(card_clk), 0);
        check("R1", int'(clk_stable), 0);
        rst_n = 1'b1;
        tick();
        check("R1", int'(card_clk), 0);

        // Bypass straight after reset (R1, R3, R9).
        clk_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tick();
            check("R3", int'(card_clk), 1);
            check("R9", int'(clk_stable), (k >= 1) ? 1 : 0);
            #4;
            check("R3", int'(card_clk), 0);
        end
        clk_en = 1'b0;                 // dropped at +6, in the low phase
        tick();
        check("R3", int'(card_clk), 1); // pulse already open completes
        check("R10", int'(clk_stable), 0);
        #4;
        check("R3", int'(card_clk), 0);
        tick();
        check("R3", int'(card_clk), 0);
        tick();

        // Sweep small divisors (R4, R6).
        for (int n = 1; n <= 12; n++) begin
            write_fields(1'b1, 1'b1, n);
            run_div(n, "R4");
        end

        // Upper field alone: {3, 12} = 780 (R2).
        write_fields(1'b1, 1'b0, 3 << 8);
        run_div(780, "R2");
        // Lower field alone: {3, 255} = 1023 (R2).
        write_fields(1'b0, 1'b1, 255);
        run_div(1023, "R2");
        write_fields(1'b1, 1'b1, 256);
        run_div(256, "R4");

        // Writes while enabled are ignored (R5).
        write_fields(1'b1, 1'b1, 4);
        clk_en = 1'b1;
        tick();                        // k = 0
        hi_wr = 1'b1; hi_val = 2'd0; lo_wr = 1'b1; lo_val = 8'd9;
        tick();                        // k = 1
        hi_wr = 1'b0; lo_wr = 1'b0;
        tick(); tick(); tick();        // k = 4, low phase
        check("R5", int'(card_clk), 0);
        clk_en = 1'b0;
        tick(); tick(); tick();
        run_div(4, "R5");

        // Disable during a high phase, N = 5 (R7).
        write_fields(1'b1, 1'b1, 5);
        clk_en = 1'b1;
        tick();                        // k = 0
        tick();                        // k = 1
        clk_en = 1'b0;
        for (int k = 2; k < 10; k++) begin
            tick();
            check("R7", int'(card_clk), (k < 5) ? 1 : 0);
            check("R10", int'(clk_stable), 0);
        end

        // Divisor written just before enable, with one idle edge between (R6).
        write_fields(1'b1, 1'b1, 2);
        run_div(2, "R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule